// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

This block moves one byte in each direction over a three-wire synchronous serial link: a serial data input, a serial data output and a shift clock. The byte to send is loaded into an internal shift register while the block is idle. Raising the start input sets the busy flag and begins a transfer. When the eighth bit has been received, the busy flag drops, a one-cycle done pulse is raised and the shift register holds the received byte.

As a clock master, the block makes the shift clock itself from the system clock. Its period is two, four or eight system clock cycles, chosen by a two-bit rate select. As a clock slave, the block follows a shift clock driven from outside. That clock passes through a two-flop synchroniser and an edge detector, so it must run slower than a quarter of the system clock. In both roles the most significant bit is sent first. The output bit changes on the falling shift edge and the input bit is captured on the rising shift edge.

Top module: `sshift_if`

## Requirements
- R1: After reset, busy, done, sk_out, so and rd_data are all zero.
- R2: A load while idle places wr_data in rd_data and drives so with wr_data bit 7. A load while busy is ignored.
- R3: A start while cfg_en is low is ignored, and busy stays zero.
- R4: In master mode with cfg_rate 00 the shift clock period is 2 cycles, so busy stays high for 16 cycles and sk_out is high for 8.
- R5: In master mode with cfg_rate 01 the period is 4 cycles, so busy is high for 32 cycles and sk_out is high for 16.
- R6: In master mode with cfg_rate 10 or 11 the period is 8 cycles, so busy is high for 64 cycles and sk_out is high for 32.
- R7: Data is sent MSB first on so, which changes only on a falling shift edge. si is captured on each rising edge into bit 0 while the register shifts toward bit 7. After 8 bits, rd_data equals the received byte.
- R8: done is a single-cycle pulse, raised at the clock edge where busy clears, on the falling shift edge that follows the eighth rising edge.
- R9: In slave mode (cfg_master 0), shifting follows edges of sk_in after synchronisation, and sk_out stays low.
- R10: Clearing cfg_en during a transfer clears busy on the next clock, with no done pulse, and sk_out returns low.
- R11: sk_out is low whenever no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (instruction-cycle) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Interface enable |
| cfg_master | input | 1 | 1: internal shift clock, 0: external shift clock |
| cfg_rate | input | 2 | Master clock rate select |
| wr_en | input | 1 | Load wr_data into the shift register |
| wr_data | input | 8 | Byte to send |
| start | input | 1 | Set busy and begin a transfer |
| si | input | 1 | Serial data in |
| sk_in | input | 1 | External shift clock (slave) |
| sk_out | output | 1 | Generated shift clock (master) |
| so | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-complete pulse |
| rd_data | output | 8 | Shift register contents |

## Verification
A divider that stops at the wrong count shows up as a busy window or an sk_out high time that is not a multiple of 16 or 8 half-periods. This is visible within one transfer, between 16 and 64 cycles. A shift or capture on the wrong edge, or in the wrong order, corrupts the byte seen at so or the byte in rd_data by the end of that transfer. A busy flag that ignores the enable or the load guard shows on busy or rd_data within one cycle of the stimulus.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
   typedef enum logic [1:0] {
      RATE_DIV2  = 2'b00,
      RATE_DIV4  = 2'b01,
      RATE_DIV8A = 2'b10,
      RATE_DIV8B = 2'b11
   } rate_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/sshift_clkgen.sv
module sshift_clkgen #(
   parameter int HALF0 = 1,
   parameter int HALF1 = 2,
   parameter int HALF2 = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       sk,
   output logic       rise,
   output logic       fall
);
   localparam int HMAX = sshift_pkg::max3(HALF0, HALF1, HALF2);
   localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;
   localparam logic [CW-1:0] LIM0 = CW'(HALF0 - 1);
   localparam logic [CW-1:0] LIM1 = CW'(HALF1 - 1);
   localparam logic [CW-1:0] LIM2 = CW'(HALF2 - 1);

   if (HALF0 < 1 || HALF1 < 1 || HALF2 < 1) begin : g_bad_half
      $error("sshift_clkgen: every half period must be at least one cycle");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;
   logic          sk_q;
   logic          term;

   always_comb begin
      if (rate[1])      lim = LIM2;
      else if (rate[0]) lim = LIM1;
      else              lim = LIM0;
   end

   assign term = run && (cnt_q == lim);
   assign rise = term && !sk_q;
   assign fall = term && sk_q;
   assign sk   = sk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sk_q  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         sk_q  <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         sk_q  <= !sk_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   sk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != lim) |=> (!run || $stable(sk_q)));
   // R11
   sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sk_q);
endmodule

// File: rtl/sshift_sync.sv
module sshift_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sshift_sync: at least two synchroniser stages are needed");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] && !prev_q;
   assign fall = !chain_q[STAGES-1] && prev_q;

   // R9
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));
endmodule

// File: rtl/sshift_core.sv
module sshift_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rise,
   input  logic              fall,
   input  logic              si,
   output logic              busy,
   output logic              done,
   output logic              so,
   output logic [DATA_W-1:0] data
);
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [BW-1:0] FULL = BW'(DATA_W);

   logic [DATA_W-1:0] sreg_q;
   logic [BW-1:0]     bits_q;
   logic              busy_q;
   logic              done_q;
   logic              so_q;
   logic              load_ok;
   logic              go;

   assign load_ok = load && !busy_q;
   assign go      = en && start && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         bits_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         so_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_ok) begin
            sreg_q <= load_data;
            so_q   <= load_data[DATA_W-1];
         end
         if (!en) begin
            busy_q <= 1'b0;
         end else if (go) begin
            busy_q <= 1'b1;
            bits_q <= '0;
         end else if (busy_q) begin
            if (rise && bits_q != FULL) begin
               sreg_q <= {sreg_q[DATA_W-2:0], si};
               bits_q <= bits_q + 1'b1;
            end else if (fall) begin
               if (bits_q == FULL) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  so_q <= sreg_q[DATA_W-1];
               end
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign so   = so_q;
   assign data = sreg_q;

   // R3
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy_q);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));
   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R7
   so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && !load_ok) |=> $stable(so_q));
   // R7
   bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bits_q <= FULL);
endmodule

// File: rtl/sshift_if.sv
module sshift_if #(
   parameter int DATA_W      = 8,
   parameter int HALF0       = 1,
   parameter int HALF1       = 2,
   parameter int HALF2       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_master,
   input  logic [1:0]        cfg_rate,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start,
   input  logic              si,
   input  logic              sk_in,
   output logic              sk_out,
   output logic              so,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sshift_if: DATA_W must be at least 2");
   end

   logic m_sk, m_rise, m_fall;
   logic s_rise, s_fall;
   logic rise, fall;
   logic run_m;

   assign run_m = busy && cfg_master;

   sshift_clkgen #(.HALF0(HALF0), .HALF1(HALF1), .HALF2(HALF2)) i_clkgen (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run_m),
      .rate (cfg_rate),
      .sk   (m_sk),
      .rise (m_rise),
      .fall (m_fall)
   );

   sshift_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(sk_in),
      .rise    (s_rise),
      .fall    (s_fall)
   );

   assign rise   = cfg_master ? m_rise : s_rise;
   assign fall   = cfg_master ? m_fall : s_fall;
   assign sk_out = cfg_master && m_sk;

   sshift_core #(.DATA_W(DATA_W)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_en),
      .start    (start),
      .load     (wr_en),
      .load_data(wr_data),
      .rise     (rise),
      .fall     (fall),
      .si       (si),
      .busy     (busy),
      .done     (done),
      .so       (so),
      .data     (rd_data)
   );

   // R11
   sk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (!sk_out || busy));
   // R9
   slave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> !sk_out);
endmodule

// File: tb/test_sshift_if.sv
module test_sshift_if;
   localparam time CYC = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0;
   logic       cfg_master = 1'b1;
   logic [1:0] cfg_rate = 2'b00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       start = 1'b0;
   logic       si = 1'b0;
   logic       sk_in = 1'b0;
   logic       sk_out, so, busy, done;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #(CYC/2) clk = ~clk;

   sshift_if i_sshift_if (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
      .cfg_rate(cfg_rate), .wr_en(wr_en), .wr_data(wr_data), .start(start),
      .si(si), .sk_in(sk_in), .sk_out(sk_out), .so(so), .busy(busy),
      .done(done), .rd_data(rd_data)
   );

   // rate, tx, rx
   localparam logic [17:0] VEC [0:4] = '{
      {2'b00, 8'hA5, 8'h3C},
      {2'b01, 8'h81, 8'h7E},
      {2'b10, 8'hC3, 8'h5A},
      {2'b11, 8'h0F, 8'hF0},
      {2'b00, 8'hFF, 8'h00}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_byte(input logic [7:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   function automatic string rate_req(input logic [1:0] r);
      if (r[1]) return "R6";
      if (r[0]) return "R5";
      return "R4";
   endfunction

   task automatic master_xfer(input logic [1:0] r, input logic [7:0] tx,
                              input logic [7:0] rx, input bit poke);
      int h, bcnt, hcnt, idx, cyc;
      logic [7:0] got;
      logic prev;
      h = r[1] ? 4 : (r[0] ? 2 : 1);
      cfg_master = 1'b1; cfg_rate = r;
      load_byte(tx);
      chk(so == tx[7], "R2 so after load", so, tx[7]);
      si = rx[7]; idx = 6; bcnt = 0; hcnt = 0; cyc = 0; got = '0; prev = 1'b0;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      forever begin
         if (!busy) break;
         bcnt++; cyc++;
         if (cyc == 3 && poke) begin wr_data = 8'hFF; wr_en = 1'b1; end
         else wr_en = 1'b0;
         if (sk_out) hcnt++;
         if (sk_out && !prev) got = {got[6:0], so};
         if (!sk_out && prev && idx >= 0) begin si = rx[idx]; idx--; end
         prev = sk_out;
         @(negedge clk);
      end
      wr_en = 1'b0;
      chk(bcnt == 16*h, {rate_req(r), " busy length"}, bcnt, 16*h);
      chk(hcnt == 8*h, {rate_req(r), " sk high time"}, hcnt, 8*h);
      chk(got == tx, "R7 MSB-first data on so", got, tx);
      chk(rd_data == rx, poke ? "R2 load ignored while busy" : "R7 received byte",
          rd_data, rx);
      chk(done == 1'b1, "R8 done at busy clear", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
      chk(sk_out == 1'b0, "R11 sk idle low", sk_out, 0);
   endtask

   initial begin
      #(CYC*150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({busy, done, sk_out, so} == 4'b0, "R1 reset flags", {busy, done, sk_out, so}, 0);
      chk(rd_data == 8'h00, "R1 reset data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: start ignored while disabled
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b0, "R3 start while disabled", busy, 0);
      @(negedge clk);
      chk(busy == 1'b0, "R3 still idle", busy, 0);

      cfg_en = 1'b1;
      load_byte(8'h6B);
      chk(rd_data == 8'h6B, "R2 load while idle", rd_data, 8'h6B);

      for (int i = 0; i < 5; i++) begin
         master_xfer(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
      end

      // R2: load during a transfer has no effect
      master_xfer(2'b01, 8'h96, 8'h69, 1'b1);

      // R10: abort by disable
      cfg_rate = 2'b10;
      load_byte(8'h55);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R10 busy before abort", busy, 1);
      cfg_en = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R10 abort clears busy", busy, 0);
      chk(done == 1'b0, "R10 no done on abort", done, 0);
      chk(sk_out == 1'b0, "R10 sk low after abort", sk_out, 0);
      cfg_en = 1'b1;
      @(negedge clk);

      // R9: slave transfer on an external clock
      begin
         logic [7:0] tx, rx, got;
         bit sk_seen;
         tx = 8'hB2; rx = 8'h4D; got = '0; sk_seen = 1'b0;
         cfg_master = 1'b0;
         load_byte(tx);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
         for (int b = 7; b >= 0; b--) begin
            si = rx[b];
            repeat (6) begin @(negedge clk); if (sk_out) sk_seen = 1'b1; end
            got = {got[6:0], so};
            sk_in = 1'b1;
            repeat (6) begin @(negedge clk); if (sk_out) sk_seen = 1'b1; end
            sk_in = 1'b0;
         end
         repeat (6) @(negedge clk);
         chk(busy == 1'b0, "R9 slave transfer ends", busy, 0);
         chk(got == tx, "R9 slave so data", got, tx);
         chk(rd_data == rx, "R9 slave received byte", rd_data, rx);
         chk(sk_seen == 1'b0, "R9 sk_out low in slave", sk_seen, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule